// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block takes a bank of GPIO pad inputs and steers any of them onto one of eight interrupt lines that feed a downstream interrupt controller. Each line has its own settings. An 8-bit selector picks the pad. A mode bit chooses level or edge sensing. A polarity bit inverts the pad so that a low level or a falling edge can be sensed. A 4-bit glitch filter sets how long the input must stay stable before a change is accepted. The downstream controller always sees a level that is active high, or a pulse that rises. Sensing both edges on one line is not possible.

Software programs the block through four 32-bit registers on a simple synchronous write, combinational read bus. The select value picks the pad to use. Values at or above the number of pads actually built count as unconnected. Each selected pad passes through a two-flop synchroniser and then the polarity inversion. Next comes the filter stage, which is always one register. A zero filter value makes it a plain flop. A nonzero value N makes it wait until the input has stayed different for N ticks of a shared prescaler. In level mode the filtered signal drives the output directly. In edge mode the output is a one-cycle pulse when the filtered signal rises. The block has no data stream, so its pins are plain control and status wires with no handshake.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, all four registers read zero and every interrupt output is low.
- R2: The registers sit at byte offsets 0x0 (mode), 0x4 (selects for lines 0-3), 0x8 (selects for lines 4-7) and 0xC (filters). Address bits [3:2] choose the register. A write is taken on the clock edge while `cfg_we` is high. The select and filter registers read back the value last written. The mode register reads back only bits 0-7 and 16-23; every other bit reads zero.
- R3: Line n takes its pad number from the byte at bit (n mod 4)*8. For lines 0-3 that byte is in the register at 0x4, and for lines 4-7 it is in the register at 0x8. Only the chosen line responds to that pad.
- R4: Take a line in level mode with polarity bit clear and filter 0. Its output follows the selected pad three clock edges after the pad changes, and is still unchanged after two edges.
- R5: Setting mode bit 16+n with bit n clear makes line n active-low level. Its output is high while the pad is low and goes low three edges after the pad rises.
- R6: Setting bit n with bit 16+n clear makes line n detect rising edges. A pad rise gives an output high for exactly one cycle, three edges later. A pad fall gives no pulse.
- R7: Setting both bit n and bit 16+n makes line n detect falling edges. A pad fall gives a one-cycle pulse three edges later. A pad rise gives none.
- R8: A select value at or above the number of built pads (`NUM_PADS`) holds the line inactive, whatever the pad levels and the polarity bit.
- R9: Line n takes its filter value N from bits [4n+3:4n] of the register at 0xC. With N nonzero, a change reaches the output no earlier than edge 3+(N-1)*TICK_DIV and no later than edge 2+N*TICK_DIV after the pad changes. Other lines are unaffected.
- R10: With filter value N of 2 or more, a pad pulse shorter than TICK_DIV cycles never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| pad_in | input | NUM_PADS | GPIO pad levels (asynchronous) |
| irq_out | output | 8 | Normalised interrupt lines to the downstream controller |

## Verification
The filter window is the hardest behaviour to reach from the ports. The prescaler runs freely and cannot be seen, so the tick phase at the moment a pad changes is unknown. The bench therefore uses a small prescale division and a small pad count. It measures the number of edges until the output moves and checks that count against the computed window bounds, for several filter values and on a line whose nibble is not the lowest one. Glitch rejection is shown with a pulse one cycle shorter than the tick period. Such a pulse can span at most one tick whatever its phase, so a filter value of 2 must always hold it off.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  localparam int NUM_CH   = 8;
  localparam int SEL_W    = 8;
  localparam int FILT_W   = 4;
  localparam int REG_W    = 32;
  localparam int LOW_BASE = 16;
  localparam int PER_REG  = REG_W / SEL_W;

  typedef enum logic [1:0] {
    RG_MODE   = 2'd0,
    RG_SEL_LO = 2'd1,
    RG_SEL_HI = 2'd2,
    RG_FILT   = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic              edge_md;
    logic              act_low;
    logic [SEL_W-1:0]  sel;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;

  function automatic logic [REG_W-1:0] mode_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      m[i]            = 1'b1;
      m[LOW_BASE + i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] MODE_MASK = mode_mask();
endpackage

// File: rtl/irqmux_regs.sv
module irqmux_regs
  import irqmux_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [3:0]                    addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output chan_cfg_t [NUM_CH-1:0]        cfg
);
  logic [REG_W-1:0] mode_q, sel_lo_q, sel_hi_q, filt_q;
  reg_idx_e         idx;

  assign idx = reg_idx_e'(addr[3:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      filt_q   <= '0;
    end else if (we) begin
      case (idx)
        RG_MODE:   mode_q   <= wdata & MODE_MASK;
        RG_SEL_LO: sel_lo_q <= wdata;
        RG_SEL_HI: sel_hi_q <= wdata;
        RG_FILT:   filt_q   <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      RG_MODE:   rdata = mode_q;
      RG_SEL_LO: rdata = sel_lo_q;
      RG_SEL_HI: rdata = sel_hi_q;
      default:   rdata = filt_q;
    endcase
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
    logic [SEL_W-1:0] sel_w;
    if (ch < PER_REG) begin : g_lo
      assign sel_w = sel_lo_q[(ch % PER_REG)*SEL_W +: SEL_W];
    end else begin : g_hi
      assign sel_w = sel_hi_q[(ch % PER_REG)*SEL_W +: SEL_W];
    end
    assign cfg[ch] = '{edge_md: mode_q[ch],
                       act_low: mode_q[LOW_BASE + ch],
                       sel:     sel_w,
                       filt:    filt_q[ch*FILT_W +: FILT_W]};
  end
endmodule

// File: rtl/irqmux_prescale.sv
module irqmux_prescale #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/irqmux_chan.sv
module irqmux_chan
  import irqmux_pkg::*;
#(
  parameter int NUM_PADS = 110
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [NUM_PADS-1:0] pads,
  input  chan_cfg_t           cfg,
  output logic                flt,
  output logic                irq
);
  localparam logic [SEL_W:0] PAD_LIM = (SEL_W+1)'(NUM_PADS);

  logic              sel_ok, raw, sync1_q, sync2_q, active, prev_q;
  logic [FILT_W-1:0] cnt_q;

  assign sel_ok = ({1'b0, cfg.sel} < PAD_LIM);

  always_comb begin
    raw = 1'b0;
    for (int i = 0; i < NUM_PADS; i++) begin
      if (cfg.sel == SEL_W'(i)) raw = pads[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
    end
  end

  // Unconnected selects stay inactive after the polarity stage too.
  assign active = sel_ok & (sync2_q ^ cfg.act_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt   <= 1'b0;
      cnt_q <= '0;
    end else if (cfg.filt == '0) begin
      flt   <= active;
      cnt_q <= '0;
    end else if (active == flt) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == cfg.filt - FILT_W'(1)) begin
        flt   <= active;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= flt;
  end

  assign irq = cfg.edge_md ? (flt & ~prev_q) : flt;
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import irqmux_pkg::*;
#(
  parameter int NUM_PADS = 110,
  parameter int TICK_DIV = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [7:0]          irq_out
);
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic                   tick;
  logic [NUM_CH-1:0]      flt_vec;

  irqmux_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  irqmux_prescale #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    irqmux_chan #(.NUM_PADS(NUM_PADS)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .pads  (pad_in),
      .cfg   (cfg[ch]),
      .flt   (flt_vec[ch]),
      .irq   (irq_out[ch])
    );
  end
endmodule

// File: rtl/pad_irq_router_chk.sv
module pad_irq_router_chk
  import irqmux_pkg::*;
#(
  parameter int NUM_PADS = 110
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             cfg_addr,
  input logic [31:0]            cfg_rdata,
  input logic                   tick,
  input chan_cfg_t [NUM_CH-1:0] cfg,
  input logic [NUM_CH-1:0]      flt_vec,
  input logic [7:0]             irq_out
);
  localparam logic [SEL_W:0] PAD_LIM = (SEL_W+1)'(NUM_PADS);

  a_r2_mode_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[3:2] == 2'd0) |-> ((cfg_rdata & ~MODE_MASK) == 32'd0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[n].edge_md && irq_out[n]) |=> (!irq_out[n] || !cfg[n].edge_md));

    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[n].filt != '0 && !tick) |=> $stable(flt_vec[n]));

    a_r8_unconnected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (({1'b0, cfg[n].sel} >= PAD_LIM) && cfg[n].filt == '0) |=> !flt_vec[n]);
  end
endmodule

bind pad_irq_router pad_irq_router_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .tick      (tick),
  .cfg       (cfg),
  .flt_vec   (flt_vec),
  .irq_out   (irq_out)
);

// File: tb/test_pad_irq_router.sv
module test_pad_irq_router;
  localparam int NP  = 20;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NP-1:0] pads = '0;
  logic [7:0]    irq_out;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  logic [7:0] selv [8];

  always #4 clk = ~clk;

  pad_irq_router #(.NUM_PADS(NP), .TICK_DIV(DIV)) i_pad_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pads), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic push_sel();
    wr(4'h4, {selv[3], selv[2], selv[1], selv[0]});
    wr(4'h8, {selv[7], selv[6], selv[5], selv[4]});
  endtask

  task automatic all_sel(input logic [7:0] v);
    for (int i = 0; i < 8; i++) selv[i] = v;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input int b, input logic want, output int n);
    n = 0;
    while (irq_out[b] !== want && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    bit quiet;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a*4), d);
      chk(d == 32'd0, "R1 reg reset", d, 32'd0);
    end
    chk(irq_out == 8'd0, "R1 irq reset", {24'd0, irq_out}, 32'd0);

    // R2: readback and mode mask
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk(d == 32'h00FF_00FF, "R2 mode mask", d, 32'h00FF_00FF);
    wr(4'h0, 32'h5A3C_C3A5); rd(4'h0, d); chk(d == 32'h003C_00A5, "R2 mode mask", d, 32'h003C_00A5);
    wr(4'h4, 32'hA5C3_1E77); rd(4'h4, d); chk(d == 32'hA5C3_1E77, "R2 sel lo", d, 32'hA5C3_1E77);
    wr(4'h8, 32'h1357_9BDF); rd(4'h8, d); chk(d == 32'h1357_9BDF, "R2 sel hi", d, 32'h1357_9BDF);
    wr(4'hC, 32'h1234_5678); rd(4'hC, d); chk(d == 32'h1234_5678, "R2 filt", d, 32'h1234_5678);
    rd(4'h4, d); chk(d == 32'hA5C3_1E77, "R2 sel lo kept", d, 32'hA5C3_1E77);
    wr(4'h0, 32'd0); wr(4'hC, 32'd0);

    // R3 / R4: sweep every line over every pad
    for (int ch = 0; ch < 8; ch++) begin
      for (int p = 0; p < NP; p++) begin
        pads = '0;
        all_sel(8'hFF); selv[ch] = 8'(p);
        push_sel();
        settle();
        pads[p] = 1'b1;
        edges(2);
        chk(irq_out == 8'd0, "R4 not before edge 3", {24'd0, irq_out}, 32'd0);
        edges(1);
        chk(irq_out == 8'(1 << ch), "R3 routed line only", {24'd0, irq_out}, 32'(1 << ch));
      end
    end
    pads = '0;

    // R5: active-low level
    for (int ch = 0; ch < 8; ch++) begin
      all_sel(8'hFF); selv[ch] = 8'(ch + 3);
      push_sel();
      wr(4'h0, 32'(1) << (16 + ch));
      pads = '0; settle();
      chk(irq_out == 8'(1 << ch), "R5 low pad active", {24'd0, irq_out}, 32'(1 << ch));
      pads[ch + 3] = 1'b1; edges(3);
      chk(irq_out == 8'd0, "R5 high pad idle", {24'd0, irq_out}, 32'd0);
      pads[ch + 3] = 1'b0; edges(3);
      chk(irq_out == 8'(1 << ch), "R5 low pad again", {24'd0, irq_out}, 32'(1 << ch));
    end

    // R6: rising edge pulses
    for (int ch = 0; ch < 8; ch++) begin
      pads = '0;
      all_sel(8'hFF); selv[ch] = 8'(19 - ch);
      push_sel();
      wr(4'h0, 32'(1) << ch);
      settle();
      pads[19 - ch] = 1'b1; edges(3);
      chk(irq_out == 8'(1 << ch), "R6 pulse on rise", {24'd0, irq_out}, 32'(1 << ch));
      edges(1);
      chk(irq_out == 8'd0, "R6 pulse one cycle", {24'd0, irq_out}, 32'd0);
      settle();
      pads[19 - ch] = 1'b0;
      quiet = 1;
      for (int k = 0; k < 8; k++) begin edges(1); if (irq_out != 8'd0) quiet = 0; end
      chk(quiet, "R6 no pulse on fall", {31'd0, quiet}, 32'd1);
    end

    // R7: falling edge pulses
    for (int ch = 0; ch < 8; ch++) begin
      pads = '0;
      all_sel(8'hFF); selv[ch] = 8'(ch);
      pads[ch] = 1'b1;
      push_sel();
      wr(4'h0, (32'(1) << ch) | (32'(1) << (16 + ch)));
      settle();
      pads[ch] = 1'b0; edges(3);
      chk(irq_out == 8'(1 << ch), "R7 pulse on fall", {24'd0, irq_out}, 32'(1 << ch));
      edges(1);
      chk(irq_out == 8'd0, "R7 pulse one cycle", {24'd0, irq_out}, 32'd0);
      settle();
      pads[ch] = 1'b1;
      quiet = 1;
      for (int k = 0; k < 8; k++) begin edges(1); if (irq_out != 8'd0) quiet = 0; end
      chk(quiet, "R7 no pulse on rise", {31'd0, quiet}, 32'd1);
    end

    // R8: out-of-range selects
    for (int v = 0; v < 2; v++) begin
      all_sel(v == 0 ? 8'(NP) : 8'hFF);
      push_sel();
      for (int m = 0; m < 2; m++) begin
        wr(4'h0, m == 0 ? 32'h00FF_0000 : 32'h0000_0000);
        pads = '1; settle();
        chk(irq_out == 8'd0, "R8 unconnected pads high", {24'd0, irq_out}, 32'd0);
        pads = '0; settle();
        chk(irq_out == 8'd0, "R8 unconnected pads low", {24'd0, irq_out}, 32'd0);
      end
    end

    // R9: filter window and field position
    wr(4'h0, 32'd0);
    all_sel(8'hFF); selv[0] = 8'd0; push_sel();
    for (int f = 1; f < 4; f++) begin
      wr(4'hC, 32'(f));
      pads = '0; repeat (40) @(negedge clk);
      pads[0] = 1'b1;
      measure(0, 1'b1, n);
      chk(n >= 3 + (f-1)*DIV && n <= 2 + f*DIV, "R9 rise delay window", 32'(n), 32'(2 + f*DIV));
      repeat (40) @(negedge clk);
      pads[0] = 1'b0;
      measure(0, 1'b0, n);
      chk(n >= 3 + (f-1)*DIV && n <= 2 + f*DIV, "R9 fall delay window", 32'(n), 32'(2 + f*DIV));
    end
    all_sel(8'hFF); selv[4] = 8'd2; selv[5] = 8'd2; push_sel();
    wr(4'hC, 32'h0030_0000);
    pads = '0; repeat (40) @(negedge clk);
    pads[2] = 1'b1; edges(3);
    chk(irq_out == 8'h10, "R9 unfiltered neighbour", {24'd0, irq_out}, 32'h10);
    measure(5, 1'b1, n);
    n = n + 3;
    chk(n >= 3 + 2*DIV && n <= 2 + 3*DIV, "R9 nibble of line 5", 32'(n), 32'(2 + 3*DIV));

    // R10: glitch rejection
    pads = '0;
    all_sel(8'hFF); selv[0] = 8'd1; push_sel();
    wr(4'hC, 32'd2);
    for (int ph = 0; ph < DIV; ph++) begin
      repeat (40 + ph) @(negedge clk);
      pads[1] = 1'b1;
      repeat (DIV - 1) @(negedge clk);
      pads[1] = 1'b0;
      quiet = 1;
      for (int k = 0; k < 30; k++) begin edges(1); if (irq_out[0]) quiet = 0; end
      chk(quiet, "R10 short glitch blocked", {31'd0, quiet}, 32'd1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule